// File: doc/BRIEF.md
# Profile-Driven Linear Ramp Generator

This block produces a digital ramp word that travels between a programmable lower bound (the start word) and upper bound (the end word). One direction input selects whether the ramp climbs or descends. Climbing and descending each have their own increment and their own hold count, the number of clock cycles the output stays on one value before the next increment. The output is the start word plus an internal offset. In a synthesizer datapath it feeds the tuning, phase or amplitude input.

Increments and hold counts sit in a small write-only register bank. They may be rewritten while a ramp is in flight, which gives piecewise or bent ramps. The direction input passes through a two-flop synchronizer, and both of its edges restart the hold timer. In snap-back mode the ramp shows the end word for one cycle and then returns to the start word. It stays there until the direction input changes again.

Top module: `ramp_sweep_gen`

## Requirements
- R1: While `srst` is high and after it falls, `ramp_out` equals `start_word` and `sweep_done` is 1, until the first effect of `dir_in`.
- R2: `dir_in` is sampled by two flops. Counting edges from the first clock edge that samples a new level, `sweep_done` reflects the new direction from edge 2. The first increment of the ramp lands on edge 3+H, where H is the hold count of the new direction.
- R3: While climbing, `ramp_out` grows by the rising increment once every H rising-edge cycles. A hold count of 0 acts as 1.
- R4: A climbing step that would pass `end_word` lands exactly on it. The output then holds and `sweep_done` is 1.
- R5: While descending, `ramp_out` drops by the falling increment once every H falling-edge cycles. It lands exactly on `start_word` and holds there with `sweep_done` at 1.
- R6: For any increment, even one larger than the span, `ramp_out` never leaves the range from `start_word` to `end_word` (with `start_word` <= `end_word`). It never wraps.
- R7: With `snap_back` high, the cycle after `ramp_out` reaches `end_word` while climbing, it returns to `start_word`. It stays there with `sweep_done` at 1 until the next edge of the synchronized direction.
- R8: Rewriting an increment during a ramp changes the size of the next step.
- R9: Rewriting a hold count during a ramp takes effect when the hold timer next reloads, which happens at the next step.
- R10: Register map on `cfg_addr`: 0 is the rising increment, 1 the falling increment, 2 the rising hold count, 3 the falling hold count. Hold counts take the low 8 bits of `cfg_data`. A write completes on the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high; clears offset, timer, synchronizer and registers |
| dir_in | input | 1 | Asynchronous direction level: 1 climbs, 0 descends |
| snap_back | input | 1 | Return to start word once the end word is reached |
| start_word | input | W | Lower ramp bound |
| end_word | input | W | Upper ramp bound |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_data | input | W | Register write data |
| ramp_out | output | W | Ramp value |
| sweep_done | output | 1 | High while holding at an endpoint |

## Verification
The hardest case to reach from the ports is a change to a register that lands between two steps of a live ramp. To land it there, the bench has to know which clock edge the synchronizer delay and the hold timer place each step on. The bench counts edges from the direction change and writes a new increment, and later a new hold count, in specific idle cycles of a slow ramp. It then checks the value on the next step edge and the cycle before it. Around this, climbs and descents are swept over a grid of spans, increments (including one larger than the span) and hold counts (including zero), and each output is compared every cycle with an arithmetic closed form.

// File: rtl/ramp_pkg.sv
`timescale 1ns/1ps
package ramp_pkg;
    typedef enum logic [1:0] {
        REG_RISE_STEP = 2'd0,
        REG_FALL_STEP = 2'd1,
        REG_RISE_HOLD = 2'd2,
        REG_FALL_HOLD = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/ramp_dir_sync.sv
`timescale 1ns/1ps
module ramp_dir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic async_in,
    output logic level,
    output logic edge_up,
    output logic edge_dn
);
    // bits [STAGES-1:0] are the synchronizer, bit STAGES holds the previous level
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (srst) chain_q <= '0;
        else      chain_q <= chain_d;
    end

    assign level   = chain_q[STAGES-1];
    assign edge_up = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign edge_dn = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ramp_cfg_regs.sv
`timescale 1ns/1ps
module ramp_cfg_regs import ramp_pkg::*; #(
    parameter int W      = 32,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [W-1:0]      data,
    output logic [W-1:0]      rise_step,
    output logic [W-1:0]      fall_step,
    output logic [HOLD_W-1:0] rise_hold,
    output logic [HOLD_W-1:0] fall_hold
);
    typedef struct packed {
        logic [W-1:0]      rstep;
        logic [W-1:0]      fstep;
        logic [HOLD_W-1:0] rhold;
        logic [HOLD_W-1:0] fhold;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_sel_e'(addr))
                REG_RISE_STEP: cfg_d.rstep = data;
                REG_FALL_STEP: cfg_d.fstep = data;
                REG_RISE_HOLD: cfg_d.rhold = data[HOLD_W-1:0];
                REG_FALL_HOLD: cfg_d.fhold = data[HOLD_W-1:0];
                default:       cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (srst) cfg_q <= '0;
        else      cfg_q <= cfg_d;
    end

    assign rise_step = cfg_q.rstep;
    assign fall_step = cfg_q.fstep;
    assign rise_hold = cfg_q.rhold;
    assign fall_hold = cfg_q.fhold;

    // R10: a write to the rising increment is visible on the next cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (srst)
        (we && addr == 2'd0) |=> (rise_step == $past(data)));
endmodule

// File: rtl/ramp_hold_timer.sv
`timescale 1ns/1ps
module ramp_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              restart,
    input  logic [HOLD_W-1:0] hold,
    output logic              tick
);
    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    logic [HOLD_W-1:0] cnt_d, cnt_q;
    logic [HOLD_W-1:0] eff_hold;

    always_comb begin
        eff_hold = (hold == '0) ? ONE : hold;
        tick     = !restart && (cnt_q <= ONE);
        if (restart || cnt_q <= ONE) cnt_d = eff_hold;
        else                         cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (srst) cnt_q <= ONE;
        else      cnt_q <= cnt_d;
    end

    // R3: the counter never rests at zero, so a zero hold acts as one
    a_r3_count_nonzero: assert property (@(posedge clk) disable iff (srst)
        cnt_q != '0);
    // R9: every expiry reloads from the hold word selected at that moment
    a_r9_reload_current: assert property (@(posedge clk) disable iff (srst)
        tick |=> (cnt_q == (($past(hold) == '0) ? ONE : $past(hold))));
endmodule

// File: rtl/ramp_sweep_gen.sv
`timescale 1ns/1ps
module ramp_sweep_gen import ramp_pkg::*; #(
    parameter int W           = 32,
    parameter int HOLD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         dir_in,
    input  logic         snap_back,
    input  logic [W-1:0] start_word,
    input  logic [W-1:0] end_word,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_addr,
    input  logic [W-1:0] cfg_data,
    output logic [W-1:0] ramp_out,
    output logic         sweep_done
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         parked;
    } ramp_t;

    logic              climb, up_edge, dn_edge, dir_edge, tick;
    logic [W-1:0]      rise_step, fall_step, span, room;
    logic [HOLD_W-1:0] rise_hold, fall_hold, sel_hold;
    logic              snap_now;
    ramp_t             st_d, st_q;

    ramp_dir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .srst(srst), .async_in(dir_in),
        .level(climb), .edge_up(up_edge), .edge_dn(dn_edge)
    );

    ramp_cfg_regs #(.W(W), .HOLD_W(HOLD_W)) u_regs (
        .clk(clk), .srst(srst), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
        .rise_step(rise_step), .fall_step(fall_step),
        .rise_hold(rise_hold), .fall_hold(fall_hold)
    );

    assign dir_edge = up_edge | dn_edge;
    assign sel_hold = climb ? rise_hold : fall_hold;

    ramp_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk(clk), .srst(srst), .restart(dir_edge), .hold(sel_hold), .tick(tick)
    );

    always_comb begin
        st_d     = st_q;
        span     = end_word - start_word;
        room     = span - st_q.acc;
        snap_now = climb && snap_back && !st_q.parked && (st_q.acc == span);
        if (dir_edge) st_d.parked = 1'b0;
        if (climb) begin
            if (snap_now) begin
                st_d.acc    = '0;
                st_d.parked = 1'b1;
            end else if (tick && !st_q.parked && st_q.acc < span) begin
                // clamp: never step past the end word, so no wrap is possible
                st_d.acc = (room <= rise_step) ? span : st_q.acc + rise_step;
            end
        end else if (tick && st_q.acc != '0) begin
            st_d.acc = (st_q.acc <= fall_step) ? '0 : st_q.acc - fall_step;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign ramp_out   = start_word + st_q.acc;
    assign sweep_done = climb ? (st_q.parked || st_q.acc == span) : (st_q.acc == '0);

    // R6: the offset never exceeds the programmed span
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (srst)
        (start_word <= end_word) |-> (st_q.acc <= span));
    // R4: climbing without snap-back never moves the ramp downward
    a_r4_climb_monotonic: assert property (@(posedge clk) disable iff (srst)
        (climb && !snap_back) |=> (st_q.acc >= $past(st_q.acc)));
    // R5: descending never moves the ramp upward
    a_r5_fall_monotonic: assert property (@(posedge clk) disable iff (srst)
        !climb |=> (st_q.acc <= $past(st_q.acc)));
    // R3: between timer expiries the value is frozen
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (srst)
        (!tick && !snap_now) |=> $stable(st_q.acc));
    // R7: reaching the end in snap-back mode returns the output to start
    a_r7_snap_to_start: assert property (@(posedge clk) disable iff (srst)
        snap_now |=> (ramp_out == $past(start_word) && sweep_done));
endmodule

// File: tb/ramp_sweep_gen_tb.sv
`timescale 1ns/1ps
module ramp_sweep_gen_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         srst;
    logic         dir_in, snap_back, cfg_we;
    logic [W-1:0] start_word, end_word, cfg_data;
    logic [1:0]   cfg_addr;
    logic [W-1:0] ramp_out;
    logic         sweep_done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ramp_sweep_gen #(.W(W), .HOLD_W(8), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .srst(srst), .dir_in(dir_in), .snap_back(snap_back),
        .start_word(start_word), .end_word(end_word),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .ramp_out(ramp_out), .sweep_done(sweep_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step_cycle();
        @(negedge clk);
        cyc++;
    endtask

    task automatic write_reg(input int addr, input int data);
        cfg_we   = 1'b1;
        cfg_addr = 2'(addr);
        cfg_data = W'(data);
        step_cycle();
        cfg_we = 1'b0;
    endtask

    function automatic int eff(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    function automatic int steps_taken(input int n, input int h);
        return (n >= 3 + h) ? ((n - 3 - h) / h + 1) : 0;
    endfunction

    // Climb from start; R2, R3, R4, R6, R10 (rising registers at addr 0 and 2)
    task automatic run_rise(input int s, input int e, input int st, input int hold);
        int h, span, nmax;
        h = eff(hold); span = e - s;
        nmax = 3 + h * ((span + st - 1) / st) + 2;
        dir_in = 1'b1;
        for (int n = 1; n <= nmax; n++) begin
            int k, off;
            step_cycle();
            k = steps_taken(n, h);
            off = (k * st >= span) ? span : k * st;
            check("R3/R4/R6 rise value", ramp_out, s + off);
            check("R2/R4 rise done", sweep_done, (n < 2) ? 1 : ((k * st >= span) ? 1 : 0));
        end
    endtask

    // Descend from end; R2, R5, R6, R10 (falling registers at addr 1 and 3)
    task automatic run_fall(input int s, input int e, input int st, input int hold);
        int h, span, nmax;
        h = eff(hold); span = e - s;
        nmax = 3 + h * ((span + st - 1) / st) + 2;
        dir_in = 1'b0;
        for (int n = 1; n <= nmax; n++) begin
            int k, off;
            step_cycle();
            k = steps_taken(n, h);
            off = (k * st >= span) ? 0 : span - k * st;
            check("R5/R6 fall value", ramp_out, s + off);
            check("R2/R5 fall done", sweep_done, (n < 2) ? 1 : ((k * st >= span) ? 1 : 0));
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int starts[4], ends[4], stps[4], holds[3];
        starts = '{0, 17, 100, 60};
        ends   = '{255, 200, 101, 60};
        stps   = '{1, 4, 37, 255};
        holds  = '{0, 1, 3};

        srst = 1'b1; dir_in = 1'b0; snap_back = 1'b0; cfg_we = 1'b0;
        cfg_addr = '0; cfg_data = '0; start_word = 8'd10; end_word = 8'd200;
        repeat (3) step_cycle();
        check("R1 reset value", ramp_out, 10);
        check("R1 reset done", sweep_done, 1);
        srst = 1'b0;
        repeat (3) step_cycle();
        check("R1 after reset value", ramp_out, 10);
        check("R1 after reset done", sweep_done, 1);

        // Grid sweep over spans, increments and hold counts
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 4; i++) begin
                for (int j = 0; j < 3; j++) begin
                    int fs, fh;
                    fs = stps[(i + 1) % 4];
                    fh = holds[(j + 1) % 3];
                    start_word = W'(starts[p]);
                    end_word   = W'(ends[p]);
                    write_reg(0, stps[i]);
                    write_reg(2, holds[j]);
                    write_reg(1, fs);
                    write_reg(3, fh);
                    run_rise(starts[p], ends[p], stps[i], holds[j]);
                    run_fall(starts[p], ends[p], fs, fh);
                end
            end
        end

        // R7: snap-back, start 20 end 120, step 30, hold 2 -> end reached on edge 11
        start_word = 8'd20; end_word = 8'd120; snap_back = 1'b1;
        write_reg(0, 30); write_reg(2, 2);
        dir_in = 1'b1;
        for (int n = 1; n <= 22; n++) begin
            int k, off;
            step_cycle();
            k = steps_taken(n, 2);
            off = (k * 30 >= 100) ? 100 : k * 30;
            if (n <= 11) begin
                check("R7 climb value", ramp_out, 20 + off);
                check("R7 climb done", sweep_done, (n < 2 || n == 11) ? 1 : 0);
            end else begin
                check("R7 snapped value", ramp_out, 20);
                check("R7 snapped done", sweep_done, 1);
            end
        end
        dir_in = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            step_cycle();
            check("R7 after snap fall value", ramp_out, 20);
            check("R7 after snap fall done", sweep_done, 1);
        end
        snap_back = 1'b0;

        // R8/R9: live rewrites; start 0 end 250, step 5, hold 4 -> steps on edges 7, 11, 15
        start_word = 8'd0; end_word = 8'd250;
        write_reg(0, 5); write_reg(2, 4); write_reg(1, 255); write_reg(3, 1);
        dir_in = 1'b1;
        cyc = 0;
        while (cyc < 8) step_cycle();
        check("R3 first step", ramp_out, 5);
        write_reg(0, 9);                       // lands on edge 9
        step_cycle();                          // edge 10
        check("R8 before next step", ramp_out, 5);
        step_cycle();                          // edge 11
        check("R8 new increment used", ramp_out, 14);
        step_cycle();                          // edge 12
        write_reg(2, 2);                       // lands on edge 13
        step_cycle();                          // edge 14
        check("R9 old hold still running", ramp_out, 14);
        step_cycle();                          // edge 15, reload with 2
        check("R9 step at old spacing", ramp_out, 23);
        step_cycle();                          // edge 16
        check("R9 no step yet", ramp_out, 23);
        step_cycle();                          // edge 17
        check("R9 new hold spacing", ramp_out, 32);
        repeat (300) step_cycle();
        check("R4 clamp at end", ramp_out, 250);
        check("R4 done at end", sweep_done, 1);
        dir_in = 1'b0;
        repeat (10) step_cycle();
        check("R5 back to start", ramp_out, 0);
        check("R5 done at start", sweep_done, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule